// File: doc/BRIEF.md
# Chained Simultaneous-Sampling ADC Sequencer

This block is the master-side controller for a chain of six-channel successive-approximation converters that share one conversion-start line and one chip select. An internal period timer launches a conversion on every converter at once. The sequencer then waits for the converters' busy indication to fall. Only then does it pull chip select low and clock in the whole chain's results from the serial output of the device nearest the master.

Each completed 16-bit result is handed downstream as a one-cycle valid pulse, together with its position in the serial stream. A capture frame holds a fixed number of sample sets. When the frame is complete the sequencer stops launching conversions and waits for the host to arm it again. If a period tick arrives while a sample set is still in progress, that tick is dropped and a sticky overrun indication is raised.

The chain length, the period in system-clock cycles, the frame length, the serial clock divider and the busy synchronizer depth are all parameters. The minimum high time of the conversion-start strobe is taken from an input.

Top module: `adcChainSeq`

## Requirements
- R1: While reset is held, convSt is 0, csN is 1, sclk is 1, wordValid is 0, armed is 0 and overrun is 0.
- R2: A one-cycle arm pulse while armed is 0 sets armed. Rising edges of convSt are then spaced exactly PERIOD_TICKS clock cycles apart, and convSt rises only while armed is 1 and csN is 1.
- R3: csN falls on the third rising clock edge after busy is first sampled low following its high phase, and never while busy is high.
- R4: While csN is low, sclk shows exactly NUM_DEV*96 rising edges. While csN is high, sclk rests high.
- R5: Serial data is taken MSB first on rising sclk edges, with the device changing sdo after falling edges. After every 16th bit, wordValid pulses for one cycle with that word on wordData. wordChan counts 0, 1, ... NUM_DEV*6-1 in stream order, and csN is low whenever wordValid is high.
- R6: Each low phase of sclk lasts SCLK_DIV/2 clock cycles.
- R7: convSt falls only after csN has returned high, and stays high for at least convHighTicks cycles. When convHighTicks exceeds the conversion-plus-readout time, it stays high for exactly convHighTicks cycles.
- R8: After FRAME_LEN sample sets, armed drops to 0 and convSt stays low until the next arm pulse.
- R9: An arm pulse while armed is 1 is ignored, so the frame still ends after exactly FRAME_LEN conversions.
- R10: A period tick that occurs while a sample set is in progress starts no conversion, so the next start comes one full period later. The tick also sets overrun, which stays 1 until the next accepted arm.
- R11: An accepted arm pulse clears overrun and restarts a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Starts a capture frame when not armed |
| convHighTicks | input | HIGH_W (16) | Minimum conversion-start high time in clock cycles |
| busy | input | 1 | Converter busy indication, asynchronous |
| sdo | input | 1 | Serial data from the nearest device in the chain |
| convSt | output | 1 | Conversion-start strobe to every device |
| csN | output | 1 | Shared active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| wordValid | output | 1 | One-cycle pulse per received word |
| wordData | output | WORD_W (16) | Received word |
| wordChan | output | clog2(NUM_DEV*6) (4) | Position of the word in the stream |
| armed | output | 1 | A capture frame is in progress |
| overrun | output | 1 | Sticky: a period tick arrived during a sample set |

## Verification
Sample sets are run with fresh random words on every channel, so any bit-order, word-boundary or channel-index slip shows up as a data mismatch. A short, randomly varied busy time separates readout that is truly triggered by the busy edge from readout driven by a fixed delay. A long busy time pushes each set past one period, which tells a skipped tick apart from a queued one through the doubled start spacing and the overrun flag. A large strobe high time shows whether the strobe waits on the programmed width or only on the end of readout. Arm pulses sent mid-frame and after a halt check that the frame length is honored and that a new frame really restarts.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_READ   = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;

  typedef struct packed {
    logic timerRestart;
    logic convStart;
    logic readStart;
    logic readRun;
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int NUM_DEV      = 2,
  parameter int CH_PER_DEV   = 6,
  parameter int WORD_W       = 16,
  parameter int PERIOD_TICKS = 9766,
  parameter int SCLK_DIV     = 4,
  parameter int HIGH_W       = 16,
  localparam int NUM_CH      = NUM_DEV * CH_PER_DEV,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [HIGH_W-1:0] convHighTicks,
  input  logic              sdo,
  output logic              periodTick,
  output logic              highMet,
  output logic              readDone,
  output logic              sclk,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic [CH_W-1:0]   wordChan
);

  localparam int TOTAL_BITS = NUM_CH * WORD_W;
  localparam int PER_W      = $clog2(PERIOD_TICKS);
  localparam int HALF       = SCLK_DIV / 2;
  localparam int DIV_W      = $clog2(HALF) + 1;
  localparam int BIT_W      = $clog2(TOTAL_BITS + 1);
  localparam int WB_W       = $clog2(WORD_W);

  // Sample-period timer
  logic [PER_W-1:0] periodCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.timerRestart) begin
      periodCnt <= '0;
    end else if (periodCnt == PER_W'(PERIOD_TICKS - 1)) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  assign periodTick = (periodCnt == PER_W'(PERIOD_TICKS - 1));

  // Strobe high-time counter, saturating
  logic [HIGH_W-1:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (strobe.convStart) begin
      highCnt <= HIGH_W'(1);
    end else if (highCnt != '1) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign highMet = (highCnt >= convHighTicks);

  // Serial clock generator and receive shifter
  logic [DIV_W-1:0]  divCnt;
  logic              sclkR;
  logic [BIT_W-1:0]  bitCnt;
  logic [WB_W-1:0]   bitInWord;
  logic [CH_W-1:0]   wordIdx;
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic              sampleNow;

  assign readDone  = (bitCnt == BIT_W'(TOTAL_BITS));
  assign sampleNow = strobe.readRun && !readDone &&
                     (divCnt == DIV_W'(HALF - 1)) && !sclkR;
  assign nextWord  = {shiftReg[WORD_W-2:0], sdo};

  always_ff @(posedge clk) begin
    if (!rstN || strobe.readStart) begin
      divCnt    <= '0;
      sclkR     <= 1'b1;
      bitCnt    <= '0;
      bitInWord <= '0;
      wordIdx   <= '0;
      shiftReg  <= '0;
    end else if (strobe.readRun && !readDone) begin
      if (divCnt == DIV_W'(HALF - 1)) begin
        divCnt <= '0;
        sclkR  <= !sclkR;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (sampleNow) begin
        shiftReg <= nextWord;
        bitCnt   <= bitCnt + 1'b1;
        if (bitInWord == WB_W'(WORD_W - 1)) begin
          bitInWord <= '0;
          if (wordIdx != CH_W'(NUM_CH - 1)) begin
            wordIdx <= wordIdx + 1'b1;
          end
        end else begin
          bitInWord <= bitInWord + 1'b1;
        end
      end
    end
  end

  // Word presentation register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordChan  <= '0;
    end else begin
      wordValid <= 1'b0;
      if (sampleNow && (bitInWord == WB_W'(WORD_W - 1))) begin
        wordValid <= 1'b1;
        wordData  <= nextWord;
        wordChan  <= wordIdx;
      end
    end
  end

  assign sclk = sclkR;

endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int FRAME_LEN   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic       busy,
  input  logic       periodTick,
  input  logic       highMet,
  input  logic       readDone,
  output seqStrobe_t strobe,
  output logic       convSt,
  output logic       csN,
  output logic       armed,
  output logic       overrun
);

  localparam int FR_W = $clog2(FRAME_LEN + 1);

  // Busy synchronizer, depth chosen by parameter
  logic [SYNC_STAGES:0] busyPipe;
  logic                 busyPrev;
  logic                 busyFall;

  assign busyPipe[0] = busy;

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) busyPipe[s] <= 1'b0;
      else       busyPipe[s] <= busyPipe[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyPrev <= 1'b0;
    else       busyPrev <= busyPipe[SYNC_STAGES];
  end

  assign busyFall = busyPrev && !busyPipe[SYNC_STAGES];

  // Sequencing
  seqState_t       state;
  logic [FR_W-1:0] sampleCnt;
  logic            armStart;
  logic            tickLive;

  assign armStart = arm && !armed;
  assign tickLive = armed && periodTick;

  always_comb begin
    strobe              = '0;
    strobe.timerRestart = armStart;
    strobe.convStart    = (state == ST_IDLE) && tickLive;
    strobe.readStart    = (state == ST_CONV) && busyFall;
    strobe.readRun      = (state == ST_READ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convSt    <= 1'b0;
      csN       <= 1'b1;
      armed     <= 1'b0;
      overrun   <= 1'b0;
      sampleCnt <= '0;
    end else begin
      if (armStart) begin
        armed     <= 1'b1;
        overrun   <= 1'b0;
        sampleCnt <= '0;
      end else if (tickLive && (state != ST_IDLE)) begin
        overrun <= 1'b1;
      end

      unique case (state)
        ST_IDLE: begin
          if (tickLive) begin
            convSt <= 1'b1;
            state  <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (busyFall) begin
            csN   <= 1'b0;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (readDone) begin
            csN   <= 1'b1;
            state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          if (highMet) begin
            convSt    <= 1'b0;
            state     <= ST_IDLE;
            sampleCnt <= sampleCnt + 1'b1;
            if (sampleCnt == FR_W'(FRAME_LEN - 1)) begin
              armed <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcChainSeq.sv
module adcChainSeq
  import adcSeqPkg::*;
#(
  parameter int NUM_DEV      = 2,
  parameter int CH_PER_DEV   = 6,
  parameter int WORD_W       = 16,
  parameter int PERIOD_TICKS = 9766,
  parameter int FRAME_LEN    = 256,
  parameter int SCLK_DIV     = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int HIGH_W       = 16
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    arm,
  input  logic [HIGH_W-1:0]                       convHighTicks,
  input  logic                                    busy,
  input  logic                                    sdo,
  output logic                                    convSt,
  output logic                                    csN,
  output logic                                    sclk,
  output logic                                    wordValid,
  output logic [WORD_W-1:0]                       wordData,
  output logic [$clog2(NUM_DEV*CH_PER_DEV)-1:0]   wordChan,
  output logic                                    armed,
  output logic                                    overrun
);

  seqStrobe_t strobe;
  logic       periodTick;
  logic       highMet;
  logic       readDone;

  adcSeqCtrl #(
    .FRAME_LEN   (FRAME_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arm        (arm),
    .busy       (busy),
    .periodTick (periodTick),
    .highMet    (highMet),
    .readDone   (readDone),
    .strobe     (strobe),
    .convSt     (convSt),
    .csN        (csN),
    .armed      (armed),
    .overrun    (overrun)
  );

  adcSeqDatapath #(
    .NUM_DEV      (NUM_DEV),
    .CH_PER_DEV   (CH_PER_DEV),
    .WORD_W       (WORD_W),
    .PERIOD_TICKS (PERIOD_TICKS),
    .SCLK_DIV     (SCLK_DIV),
    .HIGH_W       (HIGH_W)
  ) dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .convHighTicks (convHighTicks),
    .sdo           (sdo),
    .periodTick    (periodTick),
    .highMet       (highMet),
    .readDone      (readDone),
    .sclk          (sclk),
    .wordValid     (wordValid),
    .wordData      (wordData),
    .wordChan      (wordChan)
  );

endmodule

// File: rtl/adcChainSeqChk.sv
module adcChainSeqChk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic convSt,
  input logic csN,
  input logic sclk,
  input logic wordValid,
  input logic armed,
  input logic overrun
);

  // R2
  conv_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convSt) |-> (armed && csN));

  // R3
  cs_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !busy);

  // R4
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  // R5
  word_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> !csN);

  // R5
  word_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R7
  conv_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convSt) |-> csN);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !convSt) |=> !convSt);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && overrun) |=> overrun);

endmodule

bind adcChainSeq adcChainSeqChk chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .convSt    (convSt),
  .csN       (csN),
  .sclk      (sclk),
  .wordValid (wordValid),
  .armed     (armed),
  .overrun   (overrun)
);

// File: tb/adcChainSeq_test.sv
`timescale 1ns/1ps
module adcChainSeq_test;

  localparam int NUM_DEV    = 2;
  localparam int NUM_CH     = NUM_DEV * 6;
  localparam int TOTAL_BITS = NUM_CH * 16;
  localparam int PERIOD     = 1200;
  localparam int FRAME_LEN  = 4;
  localparam int SCLK_DIV   = 4;
  localparam int CH_W       = $clog2(NUM_CH);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            arm = 1'b0;
  logic [15:0]     convHighTicks = 16'd4;
  logic            busy = 1'b0;
  logic            sdo = 1'b0;
  logic            convSt, csN, sclk, wordValid, armed, overrun;
  logic [15:0]     wordData;
  logic [CH_W-1:0] wordChan;

  adcChainSeq #(
    .NUM_DEV(NUM_DEV), .PERIOD_TICKS(PERIOD), .FRAME_LEN(FRAME_LEN),
    .SCLK_DIV(SCLK_DIV)
  ) uut (
    .clk(clk), .rstN(rstN), .arm(arm), .convHighTicks(convHighTicks),
    .busy(busy), .sdo(sdo), .convSt(convSt), .csN(csN), .sclk(sclk),
    .wordValid(wordValid), .wordData(wordData), .wordChan(wordChan),
    .armed(armed), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit done    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // Converter chain model
  logic [15:0] chainWords [NUM_CH];
  int bitIdx = 0;
  int busyLen = 20;
  bit busyRandom = 1;

  function automatic logic [15:0] wordFor(input int ch);
    return chainWords[ch];
  endfunction

  function automatic logic bitFor(input int idx);
    logic [15:0] w;
    w = wordFor(idx / 16);
    return w[15 - (idx % 16)];
  endfunction

  always @(posedge convSt) begin
    for (int i = 0; i < NUM_CH; i++) chainWords[i] = 16'($urandom);
  end

  always @(posedge convSt) begin
    int len;
    len = busyRandom ? int'($urandom_range(60, 8)) : busyLen;
    repeat (2) @(posedge clk);
    busy <= 1'b1;
    repeat (len) @(posedge clk);
    busy <= 1'b0;
  end

  always @(negedge csN) bitIdx = 0;

  always @(negedge sclk) begin
    if (!csN && bitIdx < TOTAL_BITS) begin
      sdo = bitFor(bitIdx);
      bitIdx++;
    end
  end

  // Port monitor
  bit  prevConv = 0, prevCs = 1, prevSclk = 1, prevBusy = 0;
  bit  haveRise = 0;
  int  lastRiseCyc = 0, busyFallCyc = 0, sclkRises = 0, lowRun = 0;
  int  convWidth = 0, convCount = 0, wordSeen = 0, expGap = PERIOD;

  always @(negedge clk) begin
    if (rstN) begin
      if (convSt && !prevConv) begin
        convCount++;
        if (haveRise) chk(cyc - lastRiseCyc == expGap, "R2/R10 start spacing", cyc - lastRiseCyc, expGap);
        haveRise = 1;
        lastRiseCyc = cyc;
        convWidth = 0;
      end
      if (convSt) convWidth++;
      if (!convSt && prevConv) begin
        chk(csN == 1'b1, "R7 strobe falls after chip select", csN, 1);
        if (convHighTicks > 16'd900)
          chk(convWidth == int'(convHighTicks), "R7 strobe width", convWidth, convHighTicks);
      end
      if (!busy && prevBusy) busyFallCyc = cyc;
      if (!csN && prevCs) begin
        chk(cyc - busyFallCyc == 3, "R3 chip select after busy fall", cyc - busyFallCyc, 3);
        sclkRises = 0;
        wordSeen = 0;
      end
      if (!csN && sclk && !prevSclk) begin
        sclkRises++;
        chk(lowRun == SCLK_DIV / 2, "R6 sclk low phase", lowRun, SCLK_DIV / 2);
      end
      if (!sclk) lowRun++;
      else lowRun = 0;
      if (csN && !prevCs)
        chk(sclkRises == TOTAL_BITS, "R4 sclk edges per transfer", sclkRises, TOTAL_BITS);
      if (wordValid) begin
        chk(wordData == wordFor(int'(wordChan)), "R5 word data", wordData, wordFor(int'(wordChan)));
        chk(int'(wordChan) == wordSeen, "R5 channel order", wordChan, wordSeen);
        wordSeen++;
      end
      prevConv = convSt;
      prevCs   = csN;
      prevSclk = sclk;
      prevBusy = busy;
    end
  end

  task automatic pulseArm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic waitHalt(input string tag);
    int n;
    n = 0;
    while (armed && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!armed, tag, armed, 0);
  endtask

  task automatic startFrame();
    haveRise = 0;
    convCount = 0;
    pulseArm();
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(convSt == 0, "R1 convSt in reset", convSt, 0);
    chk(csN == 1, "R1 csN in reset", csN, 1);
    chk(sclk == 1, "R1 sclk in reset", sclk, 1);
    chk(wordValid == 0, "R1 wordValid in reset", wordValid, 0);
    chk(armed == 0, "R1 armed in reset", armed, 0);
    chk(overrun == 0, "R1 overrun in reset", overrun, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Frame A: random busy times, arm pulse mid-frame (R2, R9)
    busyRandom = 1; convHighTicks = 16'd4; expGap = PERIOD;
    startFrame();
    chk(armed == 1, "R2 arm accepted", armed, 1);
    while (convCount < 2) @(negedge clk);
    pulseArm();
    waitHalt("R8 frame A halts");
    chk(convCount == FRAME_LEN, "R9 mid-frame arm ignored", convCount, FRAME_LEN);
    chk(overrun == 0, "R10 no overrun with short sets", overrun, 0);
    repeat (3 * PERIOD) @(negedge clk);
    chk(convCount == FRAME_LEN, "R8 no starts after halt", convCount, FRAME_LEN);

    // Frame B: programmed width longer than readout (R7)
    convHighTicks = 16'd1000;
    startFrame();
    waitHalt("R8 frame B halts");
    chk(convCount == FRAME_LEN, "R7 frame B set count", convCount, FRAME_LEN);

    // Frame C: long busy, ticks during sets are skipped (R10)
    convHighTicks = 16'd4; busyRandom = 0; busyLen = 600; expGap = 2 * PERIOD;
    startFrame();
    chk(overrun == 0, "R10 overrun clear after arm", overrun, 0);
    waitHalt("R8 frame C halts");
    chk(overrun == 1, "R10 overrun raised", overrun, 0 + 1);
    chk(convCount == FRAME_LEN, "R10 frame C set count", convCount, FRAME_LEN);

    // Frame D: re-arm clears overrun and runs a full frame (R11)
    busyRandom = 1; expGap = PERIOD;
    startFrame();
    chk(overrun == 0, "R11 re-arm clears overrun", overrun, 0);
    chk(armed == 1, "R11 re-arm accepted", armed, 1);
    waitHalt("R11 frame D halts");
    chk(convCount == FRAME_LEN, "R11 full frame after re-arm", convCount, FRAME_LEN);

    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule